// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a TFT flat panel up and down in a controlled order and gates every signal sent to the panel. It watches a power request and moves three panel control lines one step at a time. The lines are panel supply, signal drive and backlight. Between any two steps, a programmable number of frame periods must pass. Frame periods are counted on a single-cycle frame-start tick. The request is the power-enable bit qualified by the output-enable bit.

When the last step of a power-up lands, a registered status bit reports the panel as on. It reports the panel as off only when the last step of a power-down lands.

While the panel is on, the block registers the incoming pixel data, data-enable, panel clock enable and sync signals to the panel pins. It applies the blank-enable rule and the separate sync-enable bits for display power management. While the panel is not on, all of these outputs are held at zero.

Clearing the TFT enable input holds the whole block in reset.

Top module: `panel_power_seq`

## Requirements
- R1: When the request (pwrEnable AND outEnable) is 1, the lines rise one at a time in the order panelVdd, then panelSigEn, then panelBacklight.
- R2: When the request is 0, the lines fall one at a time in the order panelBacklight, then panelSigEn, then panelVdd. panelSigEn is never 1 while panelVdd is 0.
- R3: Let N be seqDelay, or 1 when seqDelay is 0. In the cycle where the request changes value, the tick count restarts and no step occurs. After that, the lines change only in the cycle after the N-th counted frameTick. The count then restarts from zero after each step.
- R4: panelOn goes to 1 in the same cycle that panelBacklight rises. It goes to 0 in the same cycle that panelVdd falls. It holds at all other times, including partway through a sequence.
- R5: If the request reverses while a sequence is running, the lines move in the new direction starting from the current step. They do not restart from all-off or all-on.
- R6: When outEnable is 0, pwrEnable has no effect: the request is 0, so the panel powers down. pixOut, dataEnOut, panelClkEn, hsyncOut and vsyncOut are 0 from the next cycle.
- R7: When panelOn was 0 in the previous cycle, pixOut, dataEnOut, panelClkEn, hsyncOut and vsyncOut are all 0.
- R8: While gated on, pixOut equals the pixIn of the previous cycle only when blankEnable was 1 and hBlank and vBlank were both 0. Otherwise pixOut is 0. dataEnOut is 1 when hBlank and vBlank were both 0.
- R9: hsyncOut follows hsyncIn only while hsyncEnable is 1, and vsyncOut follows vsyncIn only while vsyncEnable is 1. A disabled sync output stays at 0.
- R10: rst_n low, asynchronously, or tftEnable low at a clock edge clears every line, the status bit, the tick count and all gated outputs.
- R11: Every output is a register. pixel, data-enable and sync outputs show the inputs of the previous cycle, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tftEnable | input | 1 | 0 holds the block in reset |
| outEnable | input | 1 | Panel output enable; qualifies the power request |
| pwrEnable | input | 1 | Power request bit |
| seqDelay | input | 3 | Frame periods between steps (0 acts as 1) |
| blankEnable | input | 1 | 0 blanks pixel data at all times |
| hsyncEnable | input | 1 | Horizontal sync output enable |
| vsyncEnable | input | 1 | Vertical sync output enable |
| frameTick | input | 1 | Single-cycle frame-start pulse |
| pixIn | input | DATA_W | Pixel data from the pipeline |
| hBlank | input | 1 | Horizontal blanking interval |
| vBlank | input | 1 | Vertical blanking interval |
| hsyncIn | input | 1 | Horizontal sync from the timing generator |
| vsyncIn | input | 1 | Vertical sync from the timing generator |
| panelVdd | output | 1 | Panel supply control line |
| panelSigEn | output | 1 | Panel signal drive control line |
| panelBacklight | output | 1 | Backlight control line |
| panelOn | output | 1 | Read-only panel-on status |
| pixOut | output | DATA_W | Gated pixel data |
| dataEnOut | output | 1 | Gated data enable |
| panelClkEn | output | 1 | Gated panel clock enable |
| hsyncOut | output | 1 | Gated horizontal sync |
| vsyncOut | output | 1 | Gated vertical sync |

## Verification
A tick counter that is off by one, or that fails to restart on a request reversal, moves a control-line edge by at least one frame tick. This shows up at the line ports as soon as the next step lands.

A wrong level register breaks the ordering of the three lines. It can also leave panelOn out of step with the backlight and supply edges, and that is visible in the cycle of the faulty step.

A faulty gate leaks pixel or sync activity while the panel is off, or drops it while the panel is on. This is visible one cycle after the offending input.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Number of sequenced control lines: supply, signal drive, backlight.
  localparam int NUM_LINES = 3;
  localparam int LEVEL_W   = $clog2(NUM_LINES + 1);

  typedef struct packed {
    logic stepUp;    // raise the next line
    logic stepDown;  // lower the top line
    logic clear;     // synchronous hold in reset
  } seqStrobe_t;
endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tftEnable,
  input  logic               outEnable,
  input  logic               pwrEnable,
  input  logic               frameTick,
  input  logic [DELAY_W-1:0] seqDelay,
  input  logic [LEVEL_W-1:0] level,
  output seqStrobe_t         strobe
);
  localparam logic [LEVEL_W-1:0] TOP_LEVEL = LEVEL_W'(NUM_LINES);

  logic               req;
  logic               reqQ;
  logic [DELAY_W-1:0] tickCnt;
  logic [DELAY_W-1:0] delayN;
  logic [DELAY_W:0]   countNext;
  logic               needMove;
  logic               reqChanged;
  logic               fire;

  // Power request is ignored while the output enable is low.
  assign req        = pwrEnable & outEnable;
  assign reqChanged = (req != reqQ);
  assign delayN     = (seqDelay == '0) ? DELAY_W'(1) : seqDelay;
  assign needMove   = req ? (level < TOP_LEVEL) : (level != '0);
  assign countNext  = {1'b0, tickCnt} + 1'b1;
  assign fire       = !reqChanged && needMove && frameTick
                      && (countNext >= {1'b0, delayN});

  always_comb begin
    strobe          = '0;
    strobe.clear    = !tftEnable;
    strobe.stepUp   = tftEnable && fire && req;
    strobe.stepDown = tftEnable && fire && !req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ    <= 1'b0;
      tickCnt <= '0;
    end else if (!tftEnable) begin
      reqQ    <= 1'b0;
      tickCnt <= '0;
    end else begin
      reqQ <= req;
      if (reqChanged || !needMove || fire) begin
        tickCnt <= '0;
      end else if (frameTick) begin
        tickCnt <= countNext[DELAY_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqStrobe_t           strobe,
  input  logic                 outEnable,
  input  logic                 blankEnable,
  input  logic                 hsyncEnable,
  input  logic                 vsyncEnable,
  input  logic [DATA_W-1:0]    pixIn,
  input  logic                 hBlank,
  input  logic                 vBlank,
  input  logic                 hsyncIn,
  input  logic                 vsyncIn,
  output logic [LEVEL_W-1:0]   level,
  output logic [NUM_LINES-1:0] lines,
  output logic                 panelOn,
  output logic [DATA_W-1:0]    pixOut,
  output logic                 dataEnOut,
  output logic                 panelClkEn,
  output logic                 hsyncOut,
  output logic                 vsyncOut
);
  localparam logic [LEVEL_W-1:0] LAST_UP = LEVEL_W'(NUM_LINES - 1);

  logic [LEVEL_W-1:0] levelNext;
  logic               gate;
  logic               active;

  always_comb begin
    levelNext = level;
    if (strobe.stepUp)        levelNext = level + 1'b1;
    else if (strobe.stepDown) levelNext = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            level <= '0;
    else if (strobe.clear) level <= '0;
    else                   level <= levelNext;
  end

  // One register per control line, each raised while the level passes it.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lines[i] <= 1'b0;
      else if (strobe.clear) lines[i] <= 1'b0;
      else                   lines[i] <= (levelNext > LEVEL_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      panelOn <= 1'b0;
    end else if (strobe.clear) begin
      panelOn <= 1'b0;
    end else if (strobe.stepUp && level == LAST_UP) begin
      panelOn <= 1'b1;
    end else if (strobe.stepDown && level == LEVEL_W'(1)) begin
      panelOn <= 1'b0;
    end
  end

  assign gate   = panelOn && outEnable;
  assign active = !hBlank && !vBlank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixOut     <= '0;
      dataEnOut  <= 1'b0;
      panelClkEn <= 1'b0;
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
    end else if (strobe.clear) begin
      pixOut     <= '0;
      dataEnOut  <= 1'b0;
      panelClkEn <= 1'b0;
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
    end else begin
      pixOut     <= (gate && blankEnable && active) ? pixIn : '0;
      dataEnOut  <= gate && active;
      panelClkEn <= gate;
      hsyncOut   <= gate && hsyncEnable && hsyncIn;
      vsyncOut   <= gate && vsyncEnable && vsyncIn;
    end
  end
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import pps_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tftEnable,
  input  logic               outEnable,
  input  logic               pwrEnable,
  input  logic [DELAY_W-1:0] seqDelay,
  input  logic               blankEnable,
  input  logic               hsyncEnable,
  input  logic               vsyncEnable,
  input  logic               frameTick,
  input  logic [DATA_W-1:0]  pixIn,
  input  logic               hBlank,
  input  logic               vBlank,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  output logic               panelVdd,
  output logic               panelSigEn,
  output logic               panelBacklight,
  output logic               panelOn,
  output logic [DATA_W-1:0]  pixOut,
  output logic               dataEnOut,
  output logic               panelClkEn,
  output logic               hsyncOut,
  output logic               vsyncOut
);
  seqStrobe_t           strobe;
  logic [LEVEL_W-1:0]   level;
  logic [NUM_LINES-1:0] lines;

  pps_ctrl #(.DELAY_W(DELAY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tftEnable(tftEnable), .outEnable(outEnable),
    .pwrEnable(pwrEnable), .frameTick(frameTick), .seqDelay(seqDelay),
    .level(level), .strobe(strobe)
  );

  pps_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .outEnable(outEnable),
    .blankEnable(blankEnable), .hsyncEnable(hsyncEnable),
    .vsyncEnable(vsyncEnable), .pixIn(pixIn), .hBlank(hBlank),
    .vBlank(vBlank), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .level(level),
    .lines(lines), .panelOn(panelOn), .pixOut(pixOut),
    .dataEnOut(dataEnOut), .panelClkEn(panelClkEn), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut)
  );

  assign panelVdd       = lines[0];
  assign panelSigEn     = lines[1];
  assign panelBacklight = lines[2];
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tftEnable,
  input logic              outEnable,
  input logic              blankEnable,
  input logic              hsyncEnable,
  input logic              vsyncEnable,
  input logic              frameTick,
  input logic              hBlank,
  input logic              vBlank,
  input logic              hsyncIn,
  input logic              vsyncIn,
  input logic              panelVdd,
  input logic              panelSigEn,
  input logic              panelBacklight,
  input logic              panelOn,
  input logic [DATA_W-1:0] pixOut,
  input logic              dataEnOut,
  input logic              panelClkEn,
  input logic              hsyncOut,
  input logic              vsyncOut
);
  assert_order_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    panelBacklight |-> panelSigEn);

  assert_order_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    panelSigEn |-> panelVdd);

  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tftEnable && $past(tftEnable) && !$past(frameTick))
      |-> $stable({panelVdd, panelSigEn, panelBacklight}));

  assert_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panelOn) |-> $rose(panelBacklight));

  assert_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panelOn) |-> !panelVdd);

  assert_out_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!outEnable) |-> (!panelClkEn && pixOut == '0 && !dataEnOut));

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pixOut != '0 || dataEnOut || panelClkEn || hsyncOut || vsyncOut)
      |-> $past(panelOn));

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pixOut != '0) |-> $past(blankEnable && !hBlank && !vBlank));

  assert_hsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hsyncOut |-> $past(hsyncEnable && hsyncIn));

  assert_vsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vsyncOut |-> $past(vsyncEnable && vsyncIn));

  assert_tft_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tftEnable) |-> (!panelVdd && !panelOn && !panelClkEn));
endmodule

bind panel_power_seq pps_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tftEnable(tftEnable), .outEnable(outEnable),
  .blankEnable(blankEnable), .hsyncEnable(hsyncEnable),
  .vsyncEnable(vsyncEnable), .frameTick(frameTick), .hBlank(hBlank),
  .vBlank(vBlank), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
  .panelVdd(panelVdd), .panelSigEn(panelSigEn),
  .panelBacklight(panelBacklight), .panelOn(panelOn), .pixOut(pixOut),
  .dataEnOut(dataEnOut), .panelClkEn(panelClkEn), .hsyncOut(hsyncOut),
  .vsyncOut(vsyncOut)
);

// File: tb/panel_power_seq_test.sv
`timescale 1ns/1ps
module panel_power_seq_test;
  localparam int DATA_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tftEnable = 1'b0, outEnable = 1'b0, pwrEnable = 1'b0;
  logic [2:0] seqDelay = 3'd0;
  logic blankEnable = 1'b0, hsyncEnable = 1'b0, vsyncEnable = 1'b0;
  logic frameTick = 1'b0;
  logic [DATA_W-1:0] pixIn = '0;
  logic hBlank = 1'b0, vBlank = 1'b0, hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic panelVdd, panelSigEn, panelBacklight, panelOn;
  logic [DATA_W-1:0] pixOut;
  logic dataEnOut, panelClkEn, hsyncOut, vsyncOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  panel_power_seq #(.DATA_W(DATA_W), .DELAY_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .tftEnable(tftEnable), .outEnable(outEnable),
    .pwrEnable(pwrEnable), .seqDelay(seqDelay), .blankEnable(blankEnable),
    .hsyncEnable(hsyncEnable), .vsyncEnable(vsyncEnable),
    .frameTick(frameTick), .pixIn(pixIn), .hBlank(hBlank), .vBlank(vBlank),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .panelVdd(panelVdd),
    .panelSigEn(panelSigEn), .panelBacklight(panelBacklight),
    .panelOn(panelOn), .pixOut(pixOut), .dataEnOut(dataEnOut),
    .panelClkEn(panelClkEn), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );

  // Expected-value model built from the requirements.
  int mLevel, mCnt;
  bit mReqQ, mOn, mDe, mClk, mHs, mVs;
  logic [DATA_W-1:0] mPix;

  function automatic int delayFrames(input logic [2:0] d);
    return (d == 3'd0) ? 1 : int'(d);
  endfunction

  function automatic bit needStep(input bit req, input int lvl);
    return req ? (lvl < 3) : (lvl > 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !tftEnable) begin
      mLevel <= 0; mCnt <= 0; mReqQ <= 1'b0; mOn <= 1'b0;
      mPix <= '0; mDe <= 1'b0; mClk <= 1'b0; mHs <= 1'b0; mVs <= 1'b0;
    end else begin : model
      bit req, g, act;
      req = pwrEnable && outEnable;
      mReqQ <= req;
      if (req != mReqQ || !needStep(req, mLevel)) mCnt <= 0;
      else if (frameTick) begin
        if (mCnt + 1 >= delayFrames(seqDelay)) begin
          mCnt <= 0;
          mLevel <= req ? mLevel + 1 : mLevel - 1;
          if (req && mLevel == 2) mOn <= 1'b1;
          if (!req && mLevel == 1) mOn <= 1'b0;
        end else mCnt <= mCnt + 1;
      end
      g   = mOn && outEnable;
      act = !hBlank && !vBlank;
      mPix <= (g && blankEnable && act) ? pixIn : '0;
      mDe  <= g && act;
      mClk <= g;
      mHs  <= g && hsyncEnable && hsyncIn;
      mVs  <= g && vsyncEnable && vsyncIn;
    end
  end

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    cmp("R1", "panelVdd", 32'(panelVdd), 32'(mLevel >= 1));
    cmp("R2", "panelSigEn", 32'(panelSigEn), 32'(mLevel >= 2));
    cmp("R1", "panelBacklight", 32'(panelBacklight), 32'(mLevel >= 3));
    cmp("R4", "panelOn", 32'(panelOn), 32'(mOn));
    cmp("R8", "pixOut", 32'(pixOut), 32'(mPix));
    cmp("R8", "dataEnOut", 32'(dataEnOut), 32'(mDe));
    cmp("R7", "panelClkEn", 32'(panelClkEn), 32'(mClk));
    cmp("R9", "hsyncOut", 32'(hsyncOut), 32'(mHs));
    cmp("R9", "vsyncOut", 32'(vsyncOut), 32'(mVs));
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R10: reset state
    cmp("R10", "reset lines", 32'({panelVdd, panelSigEn, panelBacklight, panelOn}), 32'h0);
    cmp("R10", "reset clk", 32'(panelClkEn), 32'h0);
    rst_n = 1'b1; tftEnable = 1'b1; outEnable = 1'b1;
    blankEnable = 1'b1; hsyncEnable = 1'b1; vsyncEnable = 1'b1;
    stepN(2);

    // R3 and R1: delay 0 acts as one frame, tick every cycle
    seqDelay = 3'd0; frameTick = 1'b1; pwrEnable = 1'b1;
    stepCycle();
    cmp("R3", "no step on request change", 32'(panelVdd), 32'h0);
    stepCycle();
    cmp("R1", "vdd first", 32'({panelVdd, panelSigEn, panelBacklight}), 32'b100);
    stepCycle();
    cmp("R1", "sig second", 32'({panelVdd, panelSigEn, panelBacklight}), 32'b110);
    stepCycle();
    cmp("R4", "on with backlight", 32'({panelBacklight, panelOn}), 32'b11);

    // R11 and R8: pixel latency and blank rule
    pixIn = 18'h2A5; hBlank = 1'b0; vBlank = 1'b0;
    stepCycle();
    cmp("R11", "pixel one cycle later", 32'(pixOut), 32'h2A5);
    blankEnable = 1'b0;
    stepCycle();
    cmp("R8", "blank enable 0 blanks", 32'(pixOut), 32'h0);
    blankEnable = 1'b1; hsyncIn = 1'b1; hsyncEnable = 1'b0;
    stepCycle();
    cmp("R9", "hsync disabled", 32'(hsyncOut), 32'h0);
    hsyncEnable = 1'b1;

    // R5: reverse mid-sequence with delay 2
    seqDelay = 3'd2; pwrEnable = 1'b0;
    stepN(3);
    cmp("R2", "backlight falls first", 32'({panelVdd, panelSigEn, panelBacklight}), 32'b110);
    cmp("R4", "status holds mid-sequence", 32'(panelOn), 32'h1);
    pwrEnable = 1'b1;
    stepN(3);
    cmp("R5", "resume from current step", 32'({panelVdd, panelSigEn, panelBacklight}), 32'b111);

    // R6: output enable low ignores the power bit and gates outputs
    outEnable = 1'b0;
    stepCycle();
    cmp("R6", "clock gated", 32'(panelClkEn), 32'h0);
    stepN(8);
    cmp("R6", "powered down", 32'({panelVdd, panelOn}), 32'h0);
    outEnable = 1'b1;
    stepN(8);

    // R10: TFT enable low clears everything
    tftEnable = 1'b0;
    stepCycle();
    cmp("R10", "tft clear", 32'({panelVdd, panelSigEn, panelBacklight, panelOn}), 32'h0);
    tftEnable = 1'b1;

    // Random phase
    for (int i = 0; i < 30000; i++) begin
      frameTick = ($urandom % 4) == 0;
      pixIn = DATA_W'($urandom);
      hBlank = ($urandom % 5) == 0;
      vBlank = ($urandom % 9) == 0;
      hsyncIn = $urandom % 2;
      vsyncIn = $urandom % 2;
      if ($urandom % 50 == 0) begin
        blankEnable = ($urandom % 4) != 0;
        hsyncEnable = ($urandom % 4) != 0;
        vsyncEnable = ($urandom % 4) != 0;
      end
      if ($urandom % 300 == 0) seqDelay = 3'($urandom);
      if ($urandom % 120 == 0) pwrEnable = ~pwrEnable;
      if ($urandom % 900 == 0) outEnable = ~outEnable;
      if ($urandom % 3000 == 0) tftEnable = 1'b0;
      else if (!tftEnable && ($urandom % 4 == 0)) tftEnable = 1'b1;
      stepCycle();
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule